// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block is the write guard that sits behind the command decoder of a serial NOR flash. The decoder hands it one event per chip-select frame. Each event carries the opcode, the number of serial clocks counted in the frame, the target address, and the new protection bits for a status write. The guard replies one cycle later with an accept or reject pulse, plus a flag that says whether the program or erase target lies in the read-only region. It holds the state that these decisions depend on:
- the write-enable latch;
- four block-protect bits and a status-lock bit;
- a deep power-down flag;
- a busy flag for the program or erase operation in progress;
- a timer that inhibits writes for a fixed time after reset.

The event interface is valid/ready. The upstream raises `cmd_valid` and holds the opcode and payload stable until it sees `cmd_ready`. The event transfers on a rising edge where both are high. `cmd_ready` is low while a program or erase runs, from the accept until the cycle after the `op_done` pulse, so the next frame waits upstream. The array engine reports the end of that operation by pulsing `op_done`. All other pins are plain levels.

The protect code selects a region at the top of the array, counted in 64 KB blocks. Code 0 protects nothing. Code 15 protects everything. Code n from 1 to 14 protects the top 2^(n-1) blocks, capped at the whole array. A pin called `wp_n` can lock the protection bits. That lock is lifted while the device runs four-wire reads, because the pin then carries data.

Top module: `flash_wrguard`

## Requirements
- R1: After reset the following are all 0: `wel`, `bp`, `srwd`, `deep_pd`, `busy`, `dec_accept`, `dec_reject` and `dec_protected`. At the same time `cmd_ready` is 1 and `inhibit` is 1.
- R2: `inhibit` stays high for exactly PWRUP_CYCLES clock edges after reset release. While it is high, these opcodes are rejected: status write 0x01, page program 0x02, continuous program 0xAD, sector erase 0x20, block erase 0xD8 and chip erase 0xC7. Write enable 0x06 is still accepted.
- R3: A frame is rejected when `cmd_bits` is zero or its low three bits are not all zero, whatever its opcode.
- R4: Write enable 0x06 sets `wel` and write disable 0x04 clears it. Every opcode listed in R2 is rejected while `wel` is 0.
- R5: An accepted status write clears `wel` in the same edge that loads `bp` from `cmd_bp` and `srwd` from `cmd_srwd`. An accepted 0x02, 0xAD, 0x20, 0xD8 or 0xC7 sets `busy` and leaves `wel` set. A later `op_done` pulse while `busy` is high clears both `busy` and `wel`.
- R6: Opcode 0xB9 sets `deep_pd`. While `deep_pd` is 1, only 0xAB is accepted, and it clears `deep_pd`. Every other opcode is rejected.
- R7: The region map is as follows:
  - Block index = `cmd_addr[ADDR_W-1:16]`.
  - Code 0 protects no block. Code 15 protects every block.
  - Code n from 1 to 14 protects the top min(2^(n-1), block count) blocks.
  - An 0x02, 0xAD, 0x20 or 0xD8 aimed at a protected block is rejected, and `dec_protected` is 1 with the decision.
- R8: Chip erase 0xC7 is rejected with `dec_protected` at 1 whenever `bp` is nonzero.
- R9: A status write is rejected when `srwd` is 1, `wp_n` is 0 and `quad_mode` is 0. With `quad_mode` at 1 the pin lock does not apply.
- R10: Exactly one of `dec_accept` and `dec_reject` pulses for one cycle, in the cycle after each transfer. A rejected frame leaves `wel`, `bp`, `srwd`, `deep_pd` and `busy` unchanged.
- R11: `cmd_ready` is 0 while `busy` is 1. Opcodes outside R2, R4 and R6, for example read 0x03, are accepted and change no state. The same holds for 0xAB outside deep power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, power-up |
| cmd_valid | input | 1 | Frame event present |
| cmd_ready | output | 1 | Guard can take a frame event |
| cmd_op | input | 8 | Decoded opcode |
| cmd_bits | input | BITS_W | Serial clocks counted in the frame |
| cmd_addr | input | ADDR_W | Byte address for program or erase |
| cmd_bp | input | 4 | New protect code carried by a status write |
| cmd_srwd | input | 1 | New status-lock bit carried by a status write |
| op_done | input | 1 | Pulse: program or erase finished |
| wp_n | input | 1 | Write-protect pin, low = lock active |
| quad_mode | input | 1 | Four-wire read mode active |
| dec_accept | output | 1 | Pulse: last frame accepted |
| dec_reject | output | 1 | Pulse: last frame rejected |
| dec_protected | output | 1 | Pulse with decision: target is in protected region |
| wel | output | 1 | Write-enable latch |
| bp | output | 4 | Block-protect code |
| srwd | output | 1 | Status-lock bit |
| deep_pd | output | 1 | Deep power-down state |
| busy | output | 1 | Program or erase in progress |
| inhibit | output | 1 | Power-up write inhibit running |

## Verification
The decision logic is exercised with these input patterns:
- Each write-class opcode in four situations: during the power-up inhibit, with the latch clear, inside the protected region, and with the pin lock active. This separates every reject reason from the others.
- Frames of 0, 7, 12 and 8 clocks. These show that only the frame length decides the framing reject.
- Addresses on both sides of the region boundary for several protect codes, including codes whose block count exceeds the array. These expose off-by-one errors and shift-saturation errors in the map.
- Deep power-down entry, followed by latch, read and wake opcodes. This shows that only the wake opcode gets through, and that it is harmless outside that state.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_CP   = 8'hAD;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE   = 8'hC7;
  localparam logic [7:0] OP_DPD  = 8'hB9;
  localparam logic [7:0] OP_WAKE = 8'hAB;

  typedef enum logic [2:0] {
    K_OTHER,
    K_LATCH_ON,
    K_LATCH_OFF,
    K_STATUS_WR,
    K_REGION_WR,
    K_CHIP_WR,
    K_SLEEP,
    K_WAKE
  } cmd_kind_e;

  typedef struct packed {
    logic accept;
    logic prot;
    logic set_wel;
    logic clr_wel;
    logic load_sr;
    logic start_op;
    logic enter_pd;
    logic leave_pd;
  } verdict_t;

  function automatic cmd_kind_e classify(input logic [7:0] op);
    cmd_kind_e k;
    case (op)
      OP_WREN:                   k = K_LATCH_ON;
      OP_WRDI:                   k = K_LATCH_OFF;
      OP_WRSR:                   k = K_STATUS_WR;
      OP_PP, OP_CP, OP_SE, OP_BE: k = K_REGION_WR;
      OP_CE:                     k = K_CHIP_WR;
      OP_DPD:                    k = K_SLEEP;
      OP_WAKE:                   k = K_WAKE;
      default:                   k = K_OTHER;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/fwg_pwrup_timer.sv
module fwg_pwrup_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic inhibit
);
  generate
    if (CYCLES == 0) begin : g_none
      assign inhibit = 1'b0;
    end else begin : g_count
      localparam int CW = $clog2(CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(CYCLES);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + CW'(1);
      end

      assign inhibit = (cnt != LIMIT);
    end
  endgenerate
endmodule

// File: rtl/fwg_region_map.sv
module fwg_region_map #(
  parameter int IDX_W = 6
) (
  input  logic [3:0]       code,
  input  logic [IDX_W-1:0] blk,
  output logic             hit,
  output logic             any
);
  localparam int CW = IDX_W + 2;
  localparam logic [CW-1:0] NBLK = CW'(1) << IDX_W;

  logic [CW-1:0] nprot;
  logic [CW-1:0] blk_w;

  // Top-of-array block count for the current code, saturating at the array
  always_comb begin
    if (code == 4'd0)                       nprot = '0;
    else if (code == 4'hF)                  nprot = NBLK;
    else if ((int'(code) - 1) >= IDX_W)     nprot = NBLK;
    else                                    nprot = CW'(1) << (code - 4'd1);
  end

  assign blk_w = CW'(blk);
  assign hit   = (blk_w + nprot) >= NBLK;
  assign any   = |code;
endmodule

// File: rtl/fwg_judge.sv
module fwg_judge
  import fwg_pkg::*;
#(
  parameter int BITS_W = 16
) (
  input  logic [7:0]        op,
  input  logic [BITS_W-1:0] nbits,
  input  logic              wel,
  input  logic              srwd,
  input  logic              pd,
  input  logic              inhibit,
  input  logic              wp_n,
  input  logic              quad,
  input  logic              region_hit,
  input  logic              region_any,
  output verdict_t          v
);
  cmd_kind_e kind;
  logic      frame_ok;
  logic      pin_lock;
  logic      write_ok;

  assign kind     = classify(op);
  assign frame_ok = (nbits != '0) && (nbits[2:0] == 3'b000);
  assign pin_lock = srwd && !wp_n && !quad;
  assign write_ok = wel && !inhibit;

  always_comb begin
    v      = '0;
    v.prot = ((kind == K_REGION_WR) && region_hit) ||
             ((kind == K_CHIP_WR) && region_any);
    if (!frame_ok) begin
      v.accept = 1'b0;
    end else if (pd) begin
      if (kind == K_WAKE) begin
        v.accept   = 1'b1;
        v.leave_pd = 1'b1;
      end
    end else begin
      case (kind)
        K_LATCH_ON: begin
          v.accept  = 1'b1;
          v.set_wel = 1'b1;
        end
        K_LATCH_OFF: begin
          v.accept  = 1'b1;
          v.clr_wel = 1'b1;
        end
        K_SLEEP: begin
          v.accept   = 1'b1;
          v.enter_pd = 1'b1;
        end
        K_STATUS_WR: begin
          if (write_ok && !pin_lock) begin
            v.accept  = 1'b1;
            v.load_sr = 1'b1;
            v.clr_wel = 1'b1;
          end
        end
        K_REGION_WR, K_CHIP_WR: begin
          if (write_ok && !v.prot) begin
            v.accept   = 1'b1;
            v.start_op = 1'b1;
          end
        end
        default: v.accept = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/flash_wrguard.sv
module flash_wrguard
  import fwg_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int BLK_SHIFT    = 16,
  parameter int BITS_W       = 16,
  parameter int PWRUP_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [BITS_W-1:0] cmd_bits,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        cmd_bp,
  input  logic              cmd_srwd,
  input  logic              op_done,
  input  logic              wp_n,
  input  logic              quad_mode,
  output logic              dec_accept,
  output logic              dec_reject,
  output logic              dec_protected,
  output logic              wel,
  output logic [3:0]        bp,
  output logic              srwd,
  output logic              deep_pd,
  output logic              busy,
  output logic              inhibit
);
  localparam int IDX_W = ADDR_W - BLK_SHIFT;

  logic     xfer;
  logic     region_hit;
  logic     region_any;
  verdict_t v;
  logic     unused_addr_lo;

  assign unused_addr_lo = ^cmd_addr[BLK_SHIFT-1:0];
  assign cmd_ready      = !busy;
  assign xfer           = cmd_valid && cmd_ready;

  fwg_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .inhibit (inhibit)
  );

  fwg_region_map #(.IDX_W(IDX_W)) u_map (
    .code (bp),
    .blk  (cmd_addr[ADDR_W-1:BLK_SHIFT]),
    .hit  (region_hit),
    .any  (region_any)
  );

  fwg_judge #(.BITS_W(BITS_W)) u_judge (
    .op         (cmd_op),
    .nbits      (cmd_bits),
    .wel        (wel),
    .srwd       (srwd),
    .pd         (deep_pd),
    .inhibit    (inhibit),
    .wp_n       (wp_n),
    .quad       (quad_mode),
    .region_hit (region_hit),
    .region_any (region_any),
    .v          (v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_accept    <= 1'b0;
      dec_reject    <= 1'b0;
      dec_protected <= 1'b0;
      wel           <= 1'b0;
      bp            <= '0;
      srwd          <= 1'b0;
      deep_pd       <= 1'b0;
      busy          <= 1'b0;
    end else begin
      dec_accept    <= xfer && v.accept;
      dec_reject    <= xfer && !v.accept;
      dec_protected <= xfer && v.prot;
      if (xfer && v.accept) begin
        if (v.set_wel)  wel     <= 1'b1;
        if (v.clr_wel)  wel     <= 1'b0;
        if (v.load_sr) begin
          bp   <= cmd_bp;
          srwd <= cmd_srwd;
        end
        if (v.start_op) busy    <= 1'b1;
        if (v.enter_pd) deep_pd <= 1'b1;
        if (v.leave_pd) deep_pd <= 1'b0;
      end
      if (busy && op_done) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fwg_checker.sv
module fwg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_op,
  input logic [2:0] bits_lo,
  input logic       op_done,
  input logic       wp_n,
  input logic       quad_mode,
  input logic       dec_accept,
  input logic       dec_reject,
  input logic       wel,
  input logic [3:0] bp,
  input logic       srwd,
  input logic       deep_pd,
  input logic       busy,
  input logic       inhibit
);
  logic xfer;
  logic wr_class;
  assign xfer     = cmd_valid && cmd_ready;
  assign wr_class = (cmd_op == 8'h01) || (cmd_op == 8'h02) || (cmd_op == 8'hAD) ||
                    (cmd_op == 8'h20) || (cmd_op == 8'hD8) || (cmd_op == 8'hC7);

  assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_accept && dec_reject));

  assert_reject_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_reject |-> ($stable(wel) && $stable(bp) && $stable(srwd) && $stable(deep_pd) && $stable(busy)));

  assert_frame_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && bits_lo != 3'b000) |=> dec_reject);

  assert_inhibit_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && inhibit && wr_class) |=> dec_reject);

  assert_latch_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wel && wr_class) |=> dec_reject);

  assert_latch_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(xfer && cmd_op == 8'h06));

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> (!wel && !busy));

  assert_sleep_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && deep_pd && cmd_op != 8'hAB) |=> dec_reject);

  assert_chip_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cmd_op == 8'hC7 && bp != 4'd0) |=> dec_reject);

  assert_pin_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cmd_op == 8'h01 && srwd && !wp_n && !quad_mode) |=> dec_reject);

  assert_bp_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $past(xfer && cmd_op == 8'h01));

  assert_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (!cmd_ready || !busy));
endmodule

bind flash_wrguard fwg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .bits_lo    (cmd_bits[2:0]),
  .op_done    (op_done),
  .wp_n       (wp_n),
  .quad_mode  (quad_mode),
  .dec_accept (dec_accept),
  .dec_reject (dec_reject),
  .wel        (wel),
  .bp         (bp),
  .srwd       (srwd),
  .deep_pd    (deep_pd),
  .busy       (busy),
  .inhibit    (inhibit)
);

// File: tb/flash_wrguard_bench.sv
module flash_wrguard_bench;
  localparam int ADDR_W = 22;
  localparam int BITS_W = 16;
  localparam int PWR    = 200;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [7:0]        cmd_op = 8'h00;
  logic [BITS_W-1:0] cmd_bits = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [3:0]        cmd_bp = 4'd0;
  logic              cmd_srwd = 1'b0;
  logic              op_done = 1'b0;
  logic              wp_n = 1'b1;
  logic              quad_mode = 1'b0;
  logic              dec_accept, dec_reject, dec_protected;
  logic              wel, srwd, deep_pd, busy, inhibit;
  logic [3:0]        bp;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  flash_wrguard #(.ADDR_W(ADDR_W), .BLK_SHIFT(16), .BITS_W(BITS_W), .PWRUP_CYCLES(PWR)) u_flash_wrguard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bits(cmd_bits), .cmd_addr(cmd_addr), .cmd_bp(cmd_bp),
    .cmd_srwd(cmd_srwd), .op_done(op_done), .wp_n(wp_n), .quad_mode(quad_mode),
    .dec_accept(dec_accept), .dec_reject(dec_reject), .dec_protected(dec_protected),
    .wel(wel), .bp(bp), .srwd(srwd), .deep_pd(deep_pd), .busy(busy), .inhibit(inhibit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one frame event at a falling edge; return at the falling edge after transfer
  task automatic send(input logic [7:0] op, input int nbits, input logic [ADDR_W-1:0] a,
                      input logic [3:0] b, input logic s);
    cmd_op = op; cmd_bits = BITS_W'(nbits); cmd_addr = a; cmd_bp = b; cmd_srwd = s;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_op();
    op_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic set_bp(input logic [3:0] b, input logic s);
    send(8'h06, 8, '0, 0, 0);
    send(8'h01, 16, '0, b, s);
    chk("R5 status write accepted", dec_accept, 1);
    chk("R5 bp loaded", bp, b);
    chk("R5 wel cleared by status write", wel, 0);
  endtask

  task automatic probe(input string tag, input logic [7:0] op, input logic [ADDR_W-1:0] a,
                       input logic exp_acc, input logic exp_prot);
    send(8'h06, 8, '0, 0, 0);
    send(op, 32, a, 0, 0);
    chk({tag, " accept"}, dec_accept, exp_acc);
    chk({tag, " reject"}, dec_reject, !exp_acc);
    chk({tag, " protected flag"}, dec_protected, exp_prot);
    if (exp_acc) begin
      chk("R11 ready low while busy", cmd_ready, 0);
      chk("R5 wel held while busy", wel, 1);
      finish_op();
      chk("R5 done clears busy", busy, 0);
      chk("R5 done clears wel", wel, 0);
    end else begin
      chk("R10 wel kept on reject", wel, 1);
      send(8'h04, 8, '0, 0, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 wel", wel, 0);
    chk("R1 bp", bp, 0);
    chk("R1 srwd", srwd, 0);
    chk("R1 deep_pd", deep_pd, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 inhibit", inhibit, 1);
    chk("R1 no verdict", {dec_accept, dec_reject, dec_protected}, 0);
  endtask

  task automatic t_inhibit();
    int guard;
    send(8'h06, 8, '0, 0, 0);
    chk("R2 wren during inhibit", dec_accept, 1);
    chk("R4 wel set", wel, 1);
    send(8'h01, 16, '0, 4'd5, 0);
    chk("R2 status write blocked", dec_reject, 1);
    chk("R10 bp unchanged", bp, 0);
    chk("R10 wel unchanged", wel, 1);
    send(8'h20, 32, '0, 0, 0);
    chk("R2 erase blocked", dec_reject, 1);
    guard = 0;
    while (inhibit && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk("R2 inhibit length", cyc, PWR);
    send(8'h01, 16, '0, 4'd5, 0);
    chk("R2 status write after inhibit", dec_accept, 1);
    chk("R5 bp loaded", bp, 5);
    chk("R5 wel cleared", wel, 0);
  endtask

  task automatic t_frame();
    send(8'h06, 8, '0, 0, 0);
    send(8'h04, 7, '0, 0, 0);
    chk("R3 7-clock frame rejected", dec_reject, 1);
    chk("R3 wel kept", wel, 1);
    send(8'h04, 0, '0, 0, 0);
    chk("R3 empty frame rejected", dec_reject, 1);
    send(8'h04, 12, '0, 0, 0);
    chk("R3 12-clock frame rejected", dec_reject, 1);
    chk("R3 wel kept", wel, 1);
    send(8'h04, 8, '0, 0, 0);
    chk("R4 wrdi accepted", dec_accept, 1);
    chk("R4 wrdi clears wel", wel, 0);
  endtask

  task automatic t_latch();
    send(8'h01, 16, '0, 4'd0, 0);
    chk("R4 status write without latch", dec_reject, 1);
    chk("R4 bp kept", bp, 5);
    send(8'h20, 32, '0, 0, 0);
    chk("R4 erase without latch", dec_reject, 1);
    chk("R7 block 0 not protected by code 5", dec_protected, 0);
    @(negedge clk);
    chk("R10 reject pulse one cycle", dec_reject, 0);
  endtask

  task automatic t_region();
    set_bp(4'd2, 0);
    probe("R7 code2 block62", 8'h20, 22'h3E0000, 0, 1);
    probe("R7 code2 block61", 8'h02, 22'h3DFFFF, 1, 0);
    set_bp(4'd1, 0);
    probe("R7 code1 block63", 8'hD8, 22'h3F0000, 0, 1);
    probe("R7 code1 block62", 8'hAD, 22'h3EFFFF, 1, 0);
    set_bp(4'd6, 0);
    probe("R7 code6 block32", 8'h20, 22'h200000, 0, 1);
    probe("R7 code6 block31", 8'h20, 22'h1FFFFF, 1, 0);
    set_bp(4'd8, 0);
    probe("R7 code8 saturates", 8'h20, 22'h000000, 0, 1);
    set_bp(4'd15, 0);
    probe("R7 code15 all", 8'h02, 22'h000000, 0, 1);
  endtask

  task automatic t_chip();
    probe("R8 chip erase with code15", 8'hC7, '0, 0, 1);
    set_bp(4'd0, 0);
    probe("R8 chip erase unprotected", 8'hC7, '0, 1, 0);
  endtask

  task automatic t_pin();
    set_bp(4'd1, 1);
    chk("R9 srwd set", srwd, 1);
    wp_n = 1'b0;
    send(8'h06, 8, '0, 0, 0);
    send(8'h01, 16, '0, 4'd0, 0);
    chk("R9 pin lock rejects", dec_reject, 1);
    chk("R9 bp kept", bp, 1);
    chk("R9 srwd kept", srwd, 1);
    chk("R10 wel kept", wel, 1);
    quad_mode = 1'b1;
    send(8'h01, 16, '0, 4'd0, 0);
    chk("R9 quad mode lifts lock", dec_accept, 1);
    chk("R9 bp cleared", bp, 0);
    chk("R9 srwd cleared", srwd, 0);
    quad_mode = 1'b0;
    wp_n = 1'b1;
  endtask

  task automatic t_sleep();
    send(8'hB9, 8, '0, 0, 0);
    chk("R6 enter deep power-down", deep_pd, 1);
    send(8'h06, 8, '0, 0, 0);
    chk("R6 wren refused asleep", dec_reject, 1);
    chk("R6 wel stays clear", wel, 0);
    send(8'h03, 32, '0, 0, 0);
    chk("R6 read refused asleep", dec_reject, 1);
    send(8'hAB, 8, '0, 0, 0);
    chk("R6 wake accepted", dec_accept, 1);
    chk("R6 left deep power-down", deep_pd, 0);
    send(8'hAB, 8, '0, 0, 0);
    chk("R11 wake while awake accepted", dec_accept, 1);
    chk("R11 wake while awake no state", deep_pd, 0);
    send(8'h03, 32, 22'h123456, 4'd9, 1);
    chk("R11 read accepted", dec_accept, 1);
    chk("R11 read leaves bp", bp, 0);
    chk("R11 read leaves srwd", srwd, 0);
    chk("R11 read leaves wel", wel, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_inhibit();
    t_frame();
    t_latch();
    t_region();
    t_chip();
    t_pin();
    t_sleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule